// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block decides which of five interrupt sources a small 8-bit processor core should take next. Each source has one bit in a request register and one bit in an enable register. Both registers sit on a byte-wide register bus. A source raises its request bit with a one-cycle pulse. A source counts as pending only while its request bit and its enable bit are both set.

A master-enable latch gates every decision. When the latch is on, no service is in progress and at least one source is pending, the block takes the lowest-numbered pending source. In the next cycle it raises a one-cycle service strobe and presents a 16-bit jump vector for that source. In the same edge it clears that source's request bit and turns the master enable off, so no second interrupt can nest. A busy window of a fixed length follows each service and accounts for the cycles the core spends entering the handler.

The core sends enable and disable commands and marks each instruction boundary with a strobe. A disable command acts at once. An enable command takes effect only after a number of instruction boundaries.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request and enable registers are zero, the master enable is off, and svc_valid and svc_busy are low.
- R2: A bus write (bus_sel and bus_we high) stores bus_wdata[4:0] at the next edge. Address 0xFF0F selects the request register and 0xFFFF selects the enable register. A read (bus_sel high, bus_we low) returns combinationally 0xE0 OR the stored five bits. Any other address, and an idle bus, read as 0x00 and write nothing. Bit order, from bit 0 to bit 4: vertical blank, display status, timer, serial, keypad.
- R3: A high bit of irq_pulse sets the matching request bit at the next edge. If a bus write to the request register happens in the same cycle, the stored value is the written bits OR the pulse bits.
- R4: At an edge where the master enable is on, svc_busy is low and (request AND enable) is nonzero, the block takes a service. svc_valid is then high for exactly one cycle. A bit that is set in the request register but clear in the enable register is never serviced.
- R5: The lowest set pending bit wins. svc_vector is 0x40 + 8 × bit index: 0x40, 0x48, 0x50, 0x58 or 0x60.
- R6: In the edge that takes a service, the chosen request bit is cleared, the other request bits are kept, and the master enable turns off. A pulse for the same source in that cycle leaves its bit set.
- R7: core_ei does not turn the master enable on in the cycle it is given. The master enable turns on at the edge of the first insn_boundary strobe after the command cycle (delay of one boundary). A core_ei given while the master enable is already on leaves it on and restarts the delay.
- R8: core_di turns the master enable off at the next edge and cancels any delayed enable. When core_di and core_ei arrive in the same cycle, core_di wins.
- R9: svc_busy is high for 5 cycles, starting with the svc_valid cycle. No service is taken while svc_busy is high.
- R10: If a delayed enable completes in the same edge that takes a service, the master enable is on after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| irq_pulse | input | 5 | One-cycle request pulses, one per source |
| core_ei | input | 1 | Delayed master-enable command |
| core_di | input | 1 | Immediate master-disable command |
| insn_boundary | input | 1 | Instruction boundary strobe from the core |
| svc_valid | output | 1 | One-cycle service strobe |
| svc_vector | output | 16 | Jump vector, valid with svc_valid |
| svc_busy | output | 1 | Service cycle window active |
| mstr_en | output | 1 | Master enable state |

## Verification
Two kinds of same-cycle collision are provoked. In the first, a service is taken in the same edge that a delayed enable completes. The directed part builds this case by reloading the delay while the master enable is already on, then making a source pending so that the service lands on the next boundary. The check is that the strobe fires and the master enable is still on afterwards. In the second, a bus write to the request register meets a hardware pulse in the same cycle, and the stored value must be the union of the two. A long random phase then mixes pulses, writes, commands and boundaries. A behavioural model compares every output on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [1:0] {
    REG_NONE,
    REG_REQ,
    REG_ENA
  } reg_sel_e;

  localparam logic [15:0] DEF_REQ_ADDR = 16'hFF0F;
  localparam logic [15:0] DEF_ENA_ADDR = 16'hFFFF;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int unsigned    NSRC     = 5,
  parameter int unsigned    AW       = 16,
  parameter int unsigned    DW       = 8,
  parameter logic [AW-1:0]  REQ_ADDR = DEF_REQ_ADDR,
  parameter logic [AW-1:0]  ENA_ADDR = DEF_ENA_ADDR
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] svc_clr,
  output logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] ena_q
);
  reg_sel_e        sel;
  logic            wr_req, wr_ena, rd_req, rd_ena;
  logic            req_ce;
  logic [NSRC-1:0] req_d;
  logic            unused_wbits;

  assign unused_wbits = ^bus_wdata[DW-1:NSRC];

  // address decode
  always_comb begin
    sel = REG_NONE;
    if (bus_sel) begin
      if (bus_addr == REQ_ADDR)      sel = REG_REQ;
      else if (bus_addr == ENA_ADDR) sel = REG_ENA;
    end
  end

  assign wr_req = (sel == REG_REQ) &  bus_we;
  assign wr_ena = (sel == REG_ENA) &  bus_we;
  assign rd_req = (sel == REG_REQ) & ~bus_we;
  assign rd_ena = (sel == REG_ENA) & ~bus_we;

  // request next state: bus write, then service clear, then hardware set
  always_comb begin
    req_d  = wr_req ? bus_wdata[NSRC-1:0] : req_q;
    req_d  = (req_d & ~svc_clr) | hw_set;
    req_ce = wr_req | (|svc_clr) | (|hw_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_ce) begin
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q <= '0;
    end else if (wr_ena) begin
      ena_q <= bus_wdata[NSRC-1:0];
    end
  end

  // read mux: unused upper bits return ones
  always_comb begin
    bus_rdata = '0;
    if (rd_req) begin
      bus_rdata             = '1;
      bus_rdata[NSRC-1:0]   = req_q;
    end else if (rd_ena) begin
      bus_rdata             = '1;
      bus_rdata[NSRC-1:0]   = ena_q;
    end
  end
endmodule

// File: rtl/vic_ime.sv
module vic_ime #(
  parameter int unsigned DELAY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_en,
  input  logic cmd_dis,
  input  logic boundary,
  input  logic svc_take,
  output logic ime_q
);
  localparam int unsigned CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ime_d, done, cnt_ce;

  // countdown reaches zero on this boundary
  assign done = ~cmd_dis & ~cmd_en & boundary & (cnt_q == CW'(1));

  always_comb begin
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    if (cmd_dis) begin
      cnt_d  = '0;
      cnt_ce = 1'b1;
    end else if (cmd_en) begin
      cnt_d  = CW'(DELAY);
      cnt_ce = 1'b1;
    end else if (boundary && cnt_q != '0) begin
      cnt_d  = cnt_q - CW'(1);
      cnt_ce = 1'b1;
    end
  end

  // delayed set outranks the service clear; disable blocks the set via done
  always_comb begin
    ime_d = ime_q;
    if (done)                    ime_d = 1'b1;
    else if (cmd_dis | svc_take) ime_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ime_q <= 1'b0;
    end else begin
      ime_q <= ime_d;
    end
  end
endmodule

// File: rtl/vic_pick.sv
module vic_pick #(
  parameter int unsigned NSRC   = 5,
  parameter int unsigned VW     = 16,
  parameter int unsigned BASE   = 'h40,
  parameter int unsigned STRIDE = 8
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] ena,
  output logic            hit,
  output logic [NSRC-1:0] grant,
  output logic [VW-1:0]   vector
);
  logic [NSRC-1:0] pend;
  logic [NSRC:0]   seen;

  assign pend    = req & ena;
  assign seen[0] = 1'b0;

  // prefix chain: a bit wins only if no lower bit is pending
  for (genvar i = 0; i < NSRC; i++) begin : g_prio
    assign grant[i]  = pend[i] & ~seen[i];
    assign seen[i+1] = seen[i] | pend[i];
  end

  assign hit = seen[NSRC];

  always_comb begin
    vector = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (grant[i]) vector = vector | VW'(BASE + i * STRIDE);
    end
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned   NSRC       = 5,
  parameter int unsigned   AW         = 16,
  parameter int unsigned   DW         = 8,
  parameter int unsigned   VW         = 16,
  parameter logic [AW-1:0] REQ_ADDR   = DEF_REQ_ADDR,
  parameter logic [AW-1:0] ENA_ADDR   = DEF_ENA_ADDR,
  parameter int unsigned   VEC_BASE   = 'h40,
  parameter int unsigned   VEC_STRIDE = 8,
  parameter int unsigned   EI_DELAY   = 1,
  parameter int unsigned   SVC_CYCLES = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_pulse,
  input  logic            core_ei,
  input  logic            core_di,
  input  logic            insn_boundary,
  output logic            svc_valid,
  output logic [VW-1:0]   svc_vector,
  output logic            svc_busy,
  output logic            mstr_en
);
  localparam int unsigned BW = $clog2(SVC_CYCLES + 1);

  logic [NSRC-1:0] req_q, ena_q, grant, svc_clr;
  logic            hit, take, busy, ime_q;
  logic [VW-1:0]   pick_vec, vec_q, vec_d;
  logic [BW-1:0]   busy_q, busy_d;
  logic            busy_ce;
  logic            sv_q;

  vic_regs #(
    .NSRC(NSRC), .AW(AW), .DW(DW), .REQ_ADDR(REQ_ADDR), .ENA_ADDR(ENA_ADDR)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_set    (irq_pulse),
    .svc_clr   (svc_clr),
    .req_q     (req_q),
    .ena_q     (ena_q)
  );

  vic_pick #(
    .NSRC(NSRC), .VW(VW), .BASE(VEC_BASE), .STRIDE(VEC_STRIDE)
  ) u_pick (
    .req    (req_q),
    .ena    (ena_q),
    .hit    (hit),
    .grant  (grant),
    .vector (pick_vec)
  );

  vic_ime #(
    .DELAY(EI_DELAY)
  ) u_ime (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_en   (core_ei),
    .cmd_dis  (core_di),
    .boundary (insn_boundary),
    .svc_take (take),
    .ime_q    (ime_q)
  );

  // decision and service window next state
  always_comb begin
    busy    = (busy_q != '0);
    take    = ime_q & hit & ~busy;
    svc_clr = take ? grant : '0;
    vec_d   = pick_vec;
    busy_d  = busy_q;
    busy_ce = 1'b0;
    if (take) begin
      busy_d  = BW'(SVC_CYCLES);
      busy_ce = 1'b1;
    end else if (busy) begin
      busy_d  = busy_q - BW'(1);
      busy_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
    end else if (busy_ce) begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
    end else if (take) begin
      vec_q <= vec_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q <= 1'b0;
    end else begin
      sv_q <= take;
    end
  end

  assign svc_valid  = sv_q;
  assign svc_vector = vec_q;
  assign svc_busy   = busy;
  assign mstr_en    = ime_q;
endmodule

// File: rtl/vic_chk.sv
module vic_chk #(
  parameter int unsigned NSRC       = 5,
  parameter int unsigned VW         = 16,
  parameter int unsigned VEC_BASE   = 'h40,
  parameter int unsigned VEC_STRIDE = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_di,
  input logic          insn_boundary,
  input logic          svc_valid,
  input logic [VW-1:0] svc_vector,
  input logic          svc_busy,
  input logic          mstr_en
);
  localparam logic [VW-1:0] VLO  = VW'(VEC_BASE);
  localparam logic [VW-1:0] VHI  = VW'(VEC_BASE + (NSRC - 1) * VEC_STRIDE);
  localparam logic [VW-1:0] VSTR = VW'(VEC_STRIDE);

  // R4: strobe lasts one cycle
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |=> !svc_valid);

  // R4: a service is taken only with master enable on
  assert_strobe_needs_ime_R4: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> $past(mstr_en));

  // R5: vector lies on the vector grid
  assert_vector_grid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> (svc_vector >= VLO && svc_vector <= VHI &&
                   ((svc_vector - VLO) % VSTR) == '0));

  // R9: service window opens with the strobe
  assert_busy_with_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    svc_valid |-> svc_busy);

  // R8: disable acts at the next edge
  assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_di |=> !mstr_en);

  // R7: master enable only rises on an instruction boundary
  assert_enable_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mstr_en) |-> $past(insn_boundary));
endmodule

bind vec_irq_ctrl vic_chk #(
  .NSRC(NSRC), .VW(VW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_vic_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_di       (core_di),
  .insn_boundary (insn_boundary),
  .svc_valid     (svc_valid),
  .svc_vector    (svc_vector),
  .svc_busy      (svc_busy),
  .mstr_en       (mstr_en)
);

// File: tb/vec_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [4:0]  irq_pulse;
  logic        core_ei, core_di, insn_boundary;
  logic        svc_valid, svc_busy, mstr_en;
  logic [15:0] svc_vector;

  always #2.5 clk = ~clk;

  vec_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse), .core_ei(core_ei), .core_di(core_di),
    .insn_boundary(insn_boundary), .svc_valid(svc_valid),
    .svc_vector(svc_vector), .svc_busy(svc_busy), .mstr_en(mstr_en)
  );

  int  n_chk = 0, n_bad = 0, n_cyc = 0;
  bit  cmp_on = 1'b0, ended = 1'b0;

  // behavioural reference state
  int m_req, m_en, m_ime, m_cnt, m_busy, m_sv, m_vec;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_rd();
    if (bus_sel && !bus_we) begin
      if (bus_addr == 16'hFF0F) return 'hE0 | m_req;
      if (bus_addr == 16'hFFFF) return 'hE0 | m_en;
    end
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req = 0; m_en = 0; m_ime = 0; m_cnt = 0; m_busy = 0; m_sv = 0; m_vec = 0;
    end else begin
      int pend, idx, nreq;
      bit take, done;
      pend = m_req & m_en;
      take = (m_ime != 0) && (pend != 0) && (m_busy == 0);
      idx  = 0;
      while (take && ((pend >> idx) & 1) == 0) idx++;
      nreq = m_req;
      if (bus_sel && bus_we && bus_addr == 16'hFF0F) nreq = bus_wdata & 'h1F;
      if (take) nreq = nreq & ~(1 << idx);
      nreq = nreq | irq_pulse;
      if (bus_sel && bus_we && bus_addr == 16'hFFFF) m_en = bus_wdata & 'h1F;
      done = 0;
      if (core_di) m_cnt = 0;
      else if (core_ei) m_cnt = 1;
      else if (insn_boundary && m_cnt > 0) begin
        m_cnt--;
        done = (m_cnt == 0);
      end
      if (done) m_ime = 1;
      else if (core_di || take) m_ime = 0;
      if (take) m_busy = 5;
      else if (m_busy > 0) m_busy--;
      m_sv = take;
      if (take) m_vec = 'h40 + 8 * idx;
      m_req = nreq;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !ended) begin
      chk("R4 svc_valid", svc_valid, m_sv);
      if (m_sv != 0) chk("R5 svc_vector", svc_vector, m_vec);
      chk("R9 svc_busy", svc_busy, (m_busy != 0));
      chk("R7 mstr_en", mstr_en, m_ime);
      chk("R2 bus_rdata", bus_rdata, model_rd());
    end
  end

  task automatic finish_run();
    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 60000 && !ended) begin
      n_chk++; n_bad++;
      $display("FAIL R4 watchdog actual=%0d expected<=60000", n_cyc);
      finish_run();
    end
  end

  task automatic cyc(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [15:0] a, output int v);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #0.5;
    v = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic pulse(logic [4:0] m);
    irq_pulse = m; cyc(1); irq_pulse = 0;
  endtask

  task automatic ei();  core_ei = 1; cyc(1); core_ei = 0; endtask
  task automatic di();  core_di = 1; cyc(1); core_di = 0; endtask
  task automatic bnd(); insn_boundary = 1; cyc(1); insn_boundary = 0; endtask

  initial begin
    int v;
    rst_n = 0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    irq_pulse = 0; core_ei = 0; core_di = 0; insn_boundary = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    cmp_on = 1;

    // R1 reset state
    chk("R1 mstr_en", mstr_en, 0);
    chk("R1 svc_valid", svc_valid, 0);
    chk("R1 svc_busy", svc_busy, 0);
    rd(16'hFF0F, v); chk("R1 request reg", v, 'hE0);
    rd(16'hFFFF, v); chk("R1 enable reg", v, 'hE0);

    // R2 register bus
    wr(16'hFFFF, 8'hFF);
    rd(16'hFFFF, v); chk("R2 enable write", v, 'hFF);
    wr(16'h1234, 8'hFF);
    rd(16'hFF0F, v); chk("R2 stray write ignored", v, 'hE0);
    rd(16'h1234, v); chk("R2 unmapped read", v, 0);

    // R3 pulse set and merge with a bus write
    pulse(5'h04);
    rd(16'hFF0F, v); chk("R3 pulse sets bit", v, 'hE4);
    bus_sel = 1; bus_we = 1; bus_addr = 16'hFF0F; bus_wdata = 8'h01; irq_pulse = 5'h08;
    cyc(1);
    bus_sel = 0; bus_we = 0; irq_pulse = 0;
    rd(16'hFF0F, v); chk("R3 write merged with pulse", v, 'hE9);
    wr(16'hFF0F, 8'h00);

    // R7 delayed enable
    ei();
    chk("R7 not immediate", mstr_en, 0);
    bnd();
    chk("R7 set on boundary", mstr_en, 1);

    // R5 R6 priority, vector, clear
    pulse(5'h12);
    chk("R4 no strobe yet", svc_valid, 0);
    cyc(1);
    chk("R4 strobe", svc_valid, 1);
    chk("R5 vector bit1", svc_vector, 'h48);
    chk("R6 master enable cleared", mstr_en, 0);
    rd(16'hFF0F, v); chk("R6 only chosen bit cleared", v, 'hF0);
    cyc(1);
    chk("R4 strobe one cycle", svc_valid, 0);
    chk("R9 busy after strobe", svc_busy, 1);

    // R9 no decision while busy
    ei();
    bnd();
    for (int k = 0; k < 10 && svc_busy; k++) begin
      chk("R9 held off while busy", svc_valid, 0);
      cyc(1);
    end
    chk("R9 window closed", svc_busy, 0);
    chk("R9 no strobe at close", svc_valid, 0);
    cyc(1);
    chk("R9 service after window", svc_valid, 1);
    chk("R5 vector bit4", svc_vector, 'h60);
    cyc(6);

    // R4 masked source never serviced
    wr(16'hFFFF, 8'h0F);
    pulse(5'h10);
    ei(); bnd();
    for (int k = 0; k < 3; k++) begin
      cyc(1);
      chk("R4 masked not serviced", svc_valid, 0);
    end
    chk("R4 enable still on", mstr_en, 1);
    rd(16'hFF0F, v); chk("R4 masked request kept", v, 'hF0);

    // R8 disable and cancellation
    di();
    chk("R8 disable immediate", mstr_en, 0);
    ei(); di(); bnd();
    chk("R8 delayed enable cancelled", mstr_en, 0);
    core_ei = 1; core_di = 1; cyc(1); core_ei = 0; core_di = 0;
    bnd();
    chk("R8 disable wins over enable", mstr_en, 0);

    // R10 service and delayed enable in the same edge
    wr(16'hFFFF, 8'h00);
    ei(); bnd();
    chk("R7 enabled", mstr_en, 1);
    ei();
    chk("R7 reload keeps enable", mstr_en, 1);
    wr(16'hFFFF, 8'h1F);
    bnd();
    chk("R10 strobe", svc_valid, 1);
    chk("R10 vector", svc_vector, 'h60);
    chk("R10 enable survives", mstr_en, 1);
    cyc(6);

    // random mix compared against the model every clock
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom_range(0, 99);
      irq_pulse     = ($urandom_range(0, 5) == 0) ? 5'($urandom) : 5'h00;
      core_ei       = ($urandom_range(0, 11) == 0);
      core_di       = ($urandom_range(0, 29) == 0);
      insn_boundary = ($urandom_range(0, 2) == 0);
      bus_sel       = (r < 40);
      bus_we        = (r < 12);
      case ($urandom_range(0, 2))
        0: bus_addr = 16'hFF0F;
        1: bus_addr = 16'hFFFF;
        default: bus_addr = 16'h1234;
      endcase
      bus_wdata = 8'($urandom);
      cyc(1);
    end
    bus_sel = 0; bus_we = 0; irq_pulse = 0; core_ei = 0; core_di = 0; insn_boundary = 0;
    cyc(8);
    finish_run();
  end
endmodule